// File: doc/BRIEF.md
# Network Controller Interrupt Status Register

This block holds the interrupt status word of a network controller. The transmit and receive engines, the general-purpose timer and the bus master report events as single-cycle pulses on a 32-bit event vector. Each pulse sets a sticky cause bit at a fixed position. Software acknowledges causes by writing a word in which every 1 clears the matching status bit.

From the cause bits the block keeps two registered summary bits, one for routine completions and one for error conditions. It drives a level interrupt line that stays high while either summary is set. The read value combines the stored bits, the summaries and two process-state fields. The process-state fields are not stored: they are derived from the receive-start and transmit-start bits of the operating-mode word that the controller presents on an input.

Top module: `nic_irq_status`

## Requirements
- R1: One clock after synchronous reset, rd_data reads 0xFC000000 and irq_o is low. Bits 31:26 are cleared only by a software write of ones and are never set by events.
- R2: A 1 on ev_i at any of the cause positions 0, 1, 2, 3, 5, 6, 7, 8, 9, 11 or 13 sets that status bit at the next clock edge. The bit stays set until software clears it.
- R3: Bit 16 (normal summary) reads 1 exactly when any of the cause bits 0, 2 or 6 is set.
- R4: Bit 15 (abnormal summary) reads 1 exactly when any of the cause bits 1, 3, 5, 7, 8, 9, 11 or 13 is set.
- R5: When wr_en is high, every stored status bit whose position is 1 in wr_data is cleared at the clock edge. Positions that are 0 in wr_data keep their value.
- R6: irq_o is high while bit 15 or bit 16 reads 1, and low otherwise.
- R7: rd_data[19:17] reads 3 when mode_i[1] is 1 and 0 otherwise. rd_data[22:20] reads 3 when mode_i[13] is 1 and 0 otherwise. No other mode_i bit affects rd_data.
- R8: Events at positions that are neither cause positions nor 31:26 have no effect. Those read positions show only the summaries and the process fields.
- R9: When an event and a software clear hit the same bit in the same cycle, the bit ends up set.
- R10: The summary bits and irq_o change one clock after the cause bits they depend on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ev_i | input | 32 | Event pulses, one bit per status position |
| wr_en | input | 1 | Software write strobe for the status word |
| wr_data | input | 32 | Write data; ones clear the matching status bits |
| mode_i | input | 32 | Current operating-mode word |
| rd_data | output | 32 | Composed status read value |
| irq_o | output | 1 | Level interrupt request |

## Verification
The assertions take event pulses and clear strobes as clean, known values on every clock edge once reset is released. Their history checks arm only from the second edge after reset, so they never look back into a reset cycle. The stimulus changes every input on the falling edge and holds reset for several cycles before releasing it. It lets events and clears coincide only where the priority rule is the subject of the test.

// File: rtl/nic_irq_pkg.sv
package nic_irq_pkg;

    localparam int REG_W = 32;

    // Cause groups feeding the two summaries
    localparam logic [REG_W-1:0] NORM_GRP  = 32'h0000_0045;
    localparam logic [REG_W-1:0] ABN_GRP   = 32'h0000_2BAA;
    localparam logic [REG_W-1:0] CAUSE_MSK = NORM_GRP | ABN_GRP;
    // High bits that leave reset set and can only be cleared
    localparam logic [REG_W-1:0] HIGH_MSK  = 32'hFC00_0000;

    localparam int NSUM_POS = 16;
    localparam int ASUM_POS = 15;

    localparam int ST_W     = 3;
    localparam int RXST_LSB = 17;
    localparam int TXST_LSB = 20;
    localparam int MODE_RX_POS = 1;
    localparam int MODE_TX_POS = 13;

    localparam logic [ST_W-1:0] ST_RUN  = 3'd3;
    localparam logic [ST_W-1:0] ST_STOP = 3'd0;

    typedef enum logic [1:0] {
        KIND_CAUSE,
        KIND_HIGH,
        KIND_NONE
    } bit_kind_e;

    typedef struct packed {
        logic nsum;
        logic asum;
    } summ_t;

    function automatic bit_kind_e kind_of(input int pos);
        if (CAUSE_MSK[pos])     return KIND_CAUSE;
        else if (HIGH_MSK[pos]) return KIND_HIGH;
        else                    return KIND_NONE;
    endfunction

    function automatic logic [ST_W-1:0] proc_state(input logic started);
        return started ? ST_RUN : ST_STOP;
    endfunction

endpackage

// File: rtl/nic_irq_cause_bank.sv
module nic_irq_cause_bank
    import nic_irq_pkg::*;
#(
    parameter int W = REG_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] ev,
    input  logic         clr_en,
    input  logic [W-1:0] clr_data,
    output logic [W-1:0] state_q
);

    logic [W-1:0] clr_vec;
    logic         in_unused;

    assign clr_vec   = clr_en ? clr_data : '0;
    assign in_unused = ^(ev & ~CAUSE_MSK);

    for (genvar g = 0; g < W; g++) begin : g_bit
        localparam bit_kind_e K = kind_of(g);
        if (K == KIND_CAUSE) begin : g_cause
            always_ff @(posedge clk) begin
                if (rst) state_q[g] <= 1'b0;
                else     state_q[g] <= (state_q[g] & ~clr_vec[g]) | ev[g];
            end
        end else if (K == KIND_HIGH) begin : g_high
            always_ff @(posedge clk) begin
                if (rst) state_q[g] <= 1'b1;
                else     state_q[g] <= state_q[g] & ~clr_vec[g];
            end
        end else begin : g_none
            assign state_q[g] = 1'b0;
        end
    end

    AST_EVENT_STICKS: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ((state_q & $past(ev & CAUSE_MSK)) == $past(ev & CAUSE_MSK))); // R2
    AST_CLEAR_ONES: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ((state_q & $past(clr_vec & ~ev)) == '0)); // R5
    AST_ZEROS_KEEP: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ((state_q & ($past(state_q) & ~$past(clr_vec))) == ($past(state_q) & ~$past(clr_vec)))); // R5
    AST_HIGH_NOSET: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ((state_q & HIGH_MSK & ~$past(state_q)) == '0)); // R1
    AST_EVENT_WINS: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ((state_q & $past(ev & clr_vec & CAUSE_MSK)) == $past(ev & clr_vec & CAUSE_MSK))); // R9

endmodule

// File: rtl/nic_irq_summary.sv
module nic_irq_summary
    import nic_irq_pkg::*;
#(
    parameter int W = REG_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] state_q,
    output summ_t        summ_q,
    output logic         irq_q
);

    summ_t summ_d;
    logic  st_unused;

    assign summ_d.nsum = |(state_q & NORM_GRP);
    assign summ_d.asum = |(state_q & ABN_GRP);
    assign st_unused   = ^(state_q & ~CAUSE_MSK);

    always_ff @(posedge clk) begin
        if (rst) begin
            summ_q <= '0;
            irq_q  <= 1'b0;
        end else begin
            summ_q <= summ_d;
            irq_q  <= summ_d.nsum | summ_d.asum;
        end
    end

    AST_NSUM_RISE_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(summ_q.nsum) |-> $past(|(state_q & NORM_GRP))); // R3
    AST_ASUM_RISE_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(summ_q.asum) |-> $past(|(state_q & ABN_GRP))); // R4
    AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (rst)
        irq_q == (summ_q.nsum | summ_q.asum)); // R6
    AST_IRQ_FALL_LAG: assert property (@(posedge clk) disable iff (rst)
        $fell(irq_q) |-> !$past(|(state_q & CAUSE_MSK))); // R10

endmodule

// File: rtl/nic_irq_readback.sv
module nic_irq_readback
    import nic_irq_pkg::*;
#(
    parameter int W = REG_W
) (
    input  logic [W-1:0] state_q,
    input  summ_t        summ_q,
    input  logic         rx_started,
    input  logic         tx_started,
    output logic [W-1:0] rd_data
);

    always_comb begin
        rd_data = state_q;
        rd_data[NSUM_POS] = summ_q.nsum;
        rd_data[ASUM_POS] = summ_q.asum;
        rd_data[RXST_LSB +: ST_W] = proc_state(rx_started);
        rd_data[TXST_LSB +: ST_W] = proc_state(tx_started);
    end

endmodule

// File: rtl/nic_irq_status.sv
module nic_irq_status
    import nic_irq_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [31:0] ev_i,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    input  logic [31:0] mode_i,
    output logic [31:0] rd_data,
    output logic        irq_o
);

    logic [REG_W-1:0] state_q;
    summ_t            summ_q;
    logic             mode_unused;

    assign mode_unused = ^mode_i;

    nic_irq_cause_bank #(.W(REG_W)) u_bank (
        .clk      (clk),
        .rst      (rst),
        .ev       (ev_i),
        .clr_en   (wr_en),
        .clr_data (wr_data),
        .state_q  (state_q)
    );

    nic_irq_summary #(.W(REG_W)) u_summ (
        .clk     (clk),
        .rst     (rst),
        .state_q (state_q),
        .summ_q  (summ_q),
        .irq_q   (irq_o)
    );

    nic_irq_readback #(.W(REG_W)) u_rd (
        .state_q    (state_q),
        .summ_q     (summ_q),
        .rx_started (mode_i[MODE_RX_POS]),
        .tx_started (mode_i[MODE_TX_POS]),
        .rd_data    (rd_data)
    );

    AST_RX_FIELD: assert property (@(posedge clk) disable iff (rst)
        rd_data[RXST_LSB +: ST_W] == (mode_i[MODE_RX_POS] ? 3'd3 : 3'd0)); // R7
    AST_TX_FIELD: assert property (@(posedge clk) disable iff (rst)
        rd_data[TXST_LSB +: ST_W] == (mode_i[MODE_TX_POS] ? 3'd3 : 3'd0)); // R7
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_data & ~(CAUSE_MSK | HIGH_MSK) & 32'hFF80_7FFF) == '0); // R8
    AST_NSUM_LAG: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (rd_data[NSUM_POS] == $past(|(state_q & NORM_GRP)))); // R10

endmodule

// File: tb/sim_nic_irq_status.sv
module sim_nic_irq_status;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] ev_i = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] mode_i = '0;
    logic [31:0] rd_data;
    logic        irq_o;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;   // 250 MHz

    nic_irq_status u0 (
        .clk(clk), .rst(rst), .ev_i(ev_i), .wr_en(wr_en),
        .wr_data(wr_data), .mode_i(mode_i), .rd_data(rd_data), .irq_o(irq_o)
    );

    typedef struct packed {
        logic [31:0] ev;
        logic [31:0] clr;
        logic [31:0] mode;
        logic [31:0] exp_rd;
        logic        exp_irq;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{32'h0000_0001, 32'h0, 32'h0, 32'h0001_0001, 1'b1},  // R2 R3 tx done
        '{32'h0000_0040, 32'h0, 32'h0, 32'h0001_0040, 1'b1},  // R3 rx done
        '{32'h0000_0004, 32'h0, 32'h0, 32'h0001_0004, 1'b1},  // R3 tx buffer gap
        '{32'h0000_2000, 32'h0, 32'h0, 32'h0000_A000, 1'b1},  // R4 bus fault
        '{32'h0000_000A, 32'h0, 32'h0, 32'h0000_800A, 1'b1},  // R4 two errors
        '{32'h0000_2BEF, 32'h0, 32'h0, 32'h0001_ABEF, 1'b1},  // R2 all causes
        '{32'h0000_2BEF, 32'h0000_2BAA, 32'h0, 32'h0001_0045, 1'b1}, // R5 clear errors
        '{32'h0000_0041, 32'h0000_0041, 32'h0, 32'h0, 1'b0},  // R5 R6 all acked
        '{32'h03FF_D410, 32'h0, 32'h0, 32'h0, 1'b0},          // R8 unused positions
        '{32'h0, 32'h0, 32'h0000_0002, 32'h0006_0000, 1'b0},  // R7 rx running
        '{32'h0, 32'h0, 32'h0000_2000, 32'h0030_0000, 1'b0},  // R7 tx running
        '{32'h0000_0080, 32'h0, 32'h0000_2002, 32'h0036_8080, 1'b1}, // R7 R4
        '{32'h0, 32'h0, 32'hFFFF_DFFD, 32'h0, 1'b0}           // R7 other mode bits
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    // apply inputs for one clock, then return them to idle at the next falling edge
    task automatic cycle(input logic [31:0] ev, input logic we, input logic [31:0] wd);
        ev_i = ev; wr_en = we; wr_data = wd;
        @(negedge clk);
        ev_i = '0; wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset value", rd_data, 32'hFC00_0000);
        check("R1 reset irq", {31'b0, irq_o}, 32'h0);

        cycle(32'h0, 1'b1, 32'h0400_0000);
        check("R1 R5 high bit cleared", rd_data, 32'hF800_0000);
        cycle(32'hFC00_0000, 1'b0, 32'h0);
        @(negedge clk);
        check("R1 events do not set high bits", rd_data, 32'hF800_0000);
        check("R6 no irq from high bits", {31'b0, irq_o}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            mode_i = '0;
            cycle(32'h0, 1'b1, 32'hFFFF_FFFF);
            @(negedge clk);
            mode_i = VECS[i].mode;
            cycle(VECS[i].ev, 1'b0, 32'h0);
            if (VECS[i].clr != 32'h0) cycle(32'h0, 1'b1, VECS[i].clr);
            else                      @(negedge clk);
            @(negedge clk);
            check($sformatf("vector %0d rd R2-group", i), rd_data, VECS[i].exp_rd);
            check($sformatf("vector %0d irq R6", i), {31'b0, irq_o}, {31'b0, VECS[i].exp_irq});
        end
        mode_i = '0;

        // R10: summary lags the cause bit by one clock
        cycle(32'h0, 1'b1, 32'hFFFF_FFFF);
        @(negedge clk);
        cycle(32'h0000_0040, 1'b0, 32'h0);
        check("R10 cause first", rd_data, 32'h0000_0040);
        check("R10 irq not yet", {31'b0, irq_o}, 32'h0);
        @(negedge clk);
        check("R10 summary next", rd_data, 32'h0001_0040);
        check("R10 irq next", {31'b0, irq_o}, 32'h1);
        repeat (3) @(negedge clk);
        check("R6 irq held", {31'b0, irq_o}, 32'h1);
        cycle(32'h0, 1'b1, 32'h0000_0040);
        check("R10 clear lag rd", rd_data, 32'h0001_0000);
        check("R10 clear lag irq", {31'b0, irq_o}, 32'h1);
        @(negedge clk);
        check("R6 irq dropped", {31'b0, irq_o}, 32'h0);

        // R9: event and clear of the same bit together
        cycle(32'h0000_2000, 1'b1, 32'h0000_2000);
        @(negedge clk);
        check("R9 event wins", rd_data, 32'h0000_A000);
        // R5: write of zeros changes nothing
        cycle(32'h0, 1'b1, 32'h0);
        @(negedge clk);
        check("R5 zero write", rd_data, 32'h0000_A000);

        finish_run();
    end

endmodule